// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides which interrupt the core should take next. It gathers twelve request slots: the core's reset, a power-down request, six active-low external lines, and internal pulses from a timer, two serial ports (transmit and receive each) and a DMA engine. Each slot is qualified by its own enable bit, and a slot's type decides how its request is held. Level slots follow their line. Edge slots keep a latch until the core takes the vector. A fixed priority chain picks one winner, and its 16-bit vector address is shown to the core.

The core tells the block when it takes the vector (`vecAck`) and when a handler finishes (`vecRet`). A small in-service record makes those two events gate new vectors. Without nesting, nothing new is offered while any handler runs. With nesting, only a strictly higher slot may interrupt. Software can write three registers through strobes: the enable mask, a control register, and a force/clear register for edge latches. It can also issue global enable and disable commands. Serial port 1's two slots can be handed over to two extra external lines.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rstN` is low and after its release, the reset vector 0x0000 is offered until it is acknowledged. Reset clears the mask and control registers and turns global servicing on. Acknowledging the reset vector does not mark a handler as running.
- R2: Priority runs from highest to lowest, with these vectors: reset 0x0000, power-down 0x002C, IRQ2 line 0x0004, level line L1 0x0008, level line L0 0x000C, serial 0 transmit 0x0010, serial 0 receive 0x0014, edge line E 0x0018, DMA 0x001C, serial 1 transmit or line IRQ1 0x0020, serial 1 receive or line IRQ0 0x0024, timer 0x0028. When several requests are pending, the highest one is shown.
- R3: Mask bit k (10 bits) enables the slot at priority position k+2: bit 0 is the IRQ2 line, bit 1 L1, bit 2 L0, bit 3 serial 0 transmit, bit 4 serial 0 receive, bit 5 E, bit 6 DMA, bit 7 serial 1 transmit/IRQ1, bit 8 serial 1 receive/IRQ0, bit 9 timer. A cleared bit hides its slot. Reset and power-down ignore the mask.
- R4: In the first cycle after a mask write is sampled, no vector other than reset is offered.
- R5: The global disable command blocks every vector except reset, power-down included. The enable command restores servicing. If both commands arrive in the same cycle, disable wins.
- R6: Lines L0 and L1 are always level-type. Their request lasts only while the line is low, and nothing is latched.
- R7: Line E and all internal pulses are edge-type. A falling line edge or a pulse sets a latch. The latch holds after the line returns high and is cleared when its vector is acknowledged.
- R8: Control bit 0 makes IRQ0 edge-type, bit 1 does the same for IRQ1, and bit 2 for IRQ2. When one of these bits is 0, that line is level-type. Bit 3 enables nesting.
- R9: A force/clear write uses the mask bit positions. Force bits set the latch of an edge-type slot. Clear bits drop a latch. Force on a level-type slot has no effect.
- R10: With nesting disabled, no vector except reset is offered while any handler is in service. Each `vecRet` retires the highest-priority handler in service.
- R11: With nesting enabled, a vector is offered only if its priority is strictly above every handler in service.
- R12: With `ser1AsIrq` high, slots 0x0020 and 0x0024 take their requests from lines IRQ1 and IRQ0. With it low, those slots take requests from the serial 1 pulses, and the lines are ignored.
- R13: Every input takes effect at the next rising clock edge, and the vector outputs reflect the new state in the cycle after that edge. A vector that has just been acknowledged is not shown again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irq2N | input | 1 | Configurable external line, active low |
| irql1N | input | 1 | Level-only external line L1, active low |
| irql0N | input | 1 | Level-only external line L0, active low |
| irqeN | input | 1 | Edge-only external line E, active low |
| irq1N | input | 1 | Configurable line sharing the serial 1 transmit slot |
| irq0N | input | 1 | Configurable line sharing the serial 1 receive slot |
| pdReq | input | 1 | Power-down request pulse |
| ser0TxReq | input | 1 | Serial 0 transmit pulse |
| ser0RxReq | input | 1 | Serial 0 receive pulse |
| dmaReq | input | 1 | DMA completion pulse |
| ser1TxReq | input | 1 | Serial 1 transmit pulse |
| ser1RxReq | input | 1 | Serial 1 receive pulse |
| timerReq | input | 1 | Timer pulse |
| ser1AsIrq | input | 1 | Hands serial 1 slots to lines IRQ1/IRQ0 |
| maskWr | input | 1 | Mask register write strobe |
| maskData | input | 10 | Mask write value |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlData | input | 4 | Control write value |
| forceWr | input | 1 | Force/clear write strobe |
| forceSet | input | 10 | Latch force bits |
| forceClr | input | 10 | Latch clear bits |
| intEna | input | 1 | Global enable command |
| intDis | input | 1 | Global disable command |
| vecAck | input | 1 | Core takes the shown vector |
| vecRet | input | 1 | Core returns from a handler |
| vecValid | output | 1 | A vector is offered |
| vecAddr | output | 16 | Offered vector address |

## Verification
All state changes at a rising edge, and the vector outputs are decoded from that state without further registers. So a line level, pulse, register write or command driven in one cycle shows on `vecValid`/`vecAddr` one edge later. The mask write is the exception: it needs two edges, because the blanking cycle sits in between. The bench drives on the falling edge and samples just before the following falling edge, so every check lands one edge after its stimulus. It also checks before that edge that nothing has moved early. The mask blanking cycle, the return order and the acknowledge retirement are each checked in the exact cycle they should take effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SLOTS      = 12;
  localparam int FIRST_MASKABLE = 2;
  localparam int NUM_MASKABLE   = NUM_SLOTS - FIRST_MASKABLE;
  localparam int IDX_W          = $clog2(NUM_SLOTS);
  localparam int VEC_W          = 16;
  localparam int VEC_STRIDE     = 4;
  localparam int CTRL_W         = 4;

  // Priority positions, highest first.
  localparam int SLOT_RST   = 0;
  localparam int SLOT_PD    = 1;
  localparam int SLOT_IRQ2  = 2;
  localparam int SLOT_LVL1  = 3;
  localparam int SLOT_LVL0  = 4;
  localparam int SLOT_S0TX  = 5;
  localparam int SLOT_S0RX  = 6;
  localparam int SLOT_EDGE  = 7;
  localparam int SLOT_DMA   = 8;
  localparam int SLOT_S1TX  = 9;
  localparam int SLOT_S1RX  = 10;
  localparam int SLOT_TIMER = 11;

  localparam logic [VEC_W-1:0] PD_VEC = VEC_W'((NUM_SLOTS - 1) * VEC_STRIDE);

  typedef struct packed {
    logic nestEn;
    logic irq2Edge;
    logic irq1Edge;
    logic irq0Edge;
  } irqcCtrl_t;

  typedef struct packed {
    logic                 ackStrb;
    logic [NUM_SLOTS-1:0] ackOneHot;
    logic                 retStrb;
  } irqcStrobes_t;

  function automatic logic [VEC_W-1:0] slotVector(input int idx);
    if (idx == SLOT_RST)     return '0;
    else if (idx == SLOT_PD) return PD_VEC;
    else                     return VEC_W'((idx - 1) * VEC_STRIDE);
  endfunction
endpackage

// File: rtl/irqc_req_path.sv
module irqc_req_path
  import irqc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    irq2N,
  input  logic                    irql1N,
  input  logic                    irql0N,
  input  logic                    irqeN,
  input  logic                    irq1N,
  input  logic                    irq0N,
  input  logic                    pdReq,
  input  logic                    ser0TxReq,
  input  logic                    ser0RxReq,
  input  logic                    dmaReq,
  input  logic                    ser1TxReq,
  input  logic                    ser1RxReq,
  input  logic                    timerReq,
  input  logic                    ser1AsIrq,
  input  logic                    maskWr,
  input  logic [NUM_MASKABLE-1:0] maskData,
  input  logic                    ctrlWr,
  input  logic [CTRL_W-1:0]       ctrlData,
  input  logic                    forceWr,
  input  logic [NUM_MASKABLE-1:0] forceSet,
  input  logic [NUM_MASKABLE-1:0] forceClr,
  input  logic                    intEna,
  input  logic                    intDis,
  input  irqcStrobes_t            strb,
  output logic [NUM_SLOTS-1:0]    pendVec,
  output logic [NUM_SLOTS-1:0]    inSvc,
  output logic                    nestEn,
  output logic                    globEn,
  output logic                    blank
);
  logic [NUM_SLOTS-1:1]    pinNow, pinQ, fromPin, pulse, levelSel, edgeEvt;
  logic [NUM_SLOTS-1:0]    reqRaw, svcNext;
  logic [NUM_MASKABLE-1:0] maskQ;
  irqcCtrl_t               ctrlQ;
  logic                    resetPendQ, enQ, blankQ;
  logic [NUM_SLOTS-1:0]    inSvcQ;

  // Route each source onto its priority slot.
  always_comb begin
    pinNow  = '1;
    fromPin = '0;
    pulse   = '0;
    pulse[SLOT_PD]    = pdReq;
    pinNow[SLOT_IRQ2] = irq2N;  fromPin[SLOT_IRQ2] = 1'b1;
    pinNow[SLOT_LVL1] = irql1N; fromPin[SLOT_LVL1] = 1'b1;
    pinNow[SLOT_LVL0] = irql0N; fromPin[SLOT_LVL0] = 1'b1;
    pulse[SLOT_S0TX]  = ser0TxReq;
    pulse[SLOT_S0RX]  = ser0RxReq;
    pinNow[SLOT_EDGE] = irqeN;  fromPin[SLOT_EDGE] = 1'b1;
    pulse[SLOT_DMA]   = dmaReq;
    if (ser1AsIrq) begin
      pinNow[SLOT_S1TX] = irq1N; fromPin[SLOT_S1TX] = 1'b1;
      pinNow[SLOT_S1RX] = irq0N; fromPin[SLOT_S1RX] = 1'b1;
    end else begin
      pulse[SLOT_S1TX] = ser1TxReq;
      pulse[SLOT_S1RX] = ser1RxReq;
    end
    pulse[SLOT_TIMER] = timerReq;
  end

  // Which slots currently behave as level requests.
  always_comb begin
    levelSel = '0;
    levelSel[SLOT_IRQ2] = ~ctrlQ.irq2Edge;
    levelSel[SLOT_LVL1] = 1'b1;
    levelSel[SLOT_LVL0] = 1'b1;
    levelSel[SLOT_S1TX] = ser1AsIrq & ~ctrlQ.irq1Edge;
    levelSel[SLOT_S1RX] = ser1AsIrq & ~ctrlQ.irq0Edge;
  end

  always_comb begin
    for (int s = 1; s < NUM_SLOTS; s++)
      edgeEvt[s] = fromPin[s] ? (pinQ[s] & ~pinNow[s]) : pulse[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinQ <= '1;
    else       pinQ <= pinNow;
  end

  assign reqRaw[SLOT_RST] = resetPendQ;

  generate
    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_slot
      logic latchQ, swSet, swClr, ackHit;
      if (s >= FIRST_MASKABLE) begin : g_sw
        assign swSet = forceWr & forceSet[s-FIRST_MASKABLE] & ~levelSel[s];
        assign swClr = forceWr & forceClr[s-FIRST_MASKABLE];
      end else begin : g_hw
        assign swSet = 1'b0;
        assign swClr = 1'b0;
      end
      assign ackHit = strb.ackStrb & strb.ackOneHot[s];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) latchQ <= 1'b0;
        else       latchQ <= (latchQ & ~ackHit & ~swClr)
                           | (edgeEvt[s] & ~levelSel[s]) | swSet;
      end
      assign reqRaw[s] = levelSel[s] ? ~pinQ[s] : latchQ;
    end
  endgenerate

  // In-service record: a return retires the highest running handler.
  always_comb begin
    svcNext = inSvcQ;
    if (strb.retStrb) svcNext = svcNext & (svcNext - 1'b1);
    if (strb.ackStrb) svcNext = svcNext | (strb.ackOneHot & ~NUM_SLOTS'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetPendQ <= 1'b1;
      enQ        <= 1'b1;
      blankQ     <= 1'b0;
      maskQ      <= '0;
      ctrlQ      <= '0;
      inSvcQ     <= '0;
    end else begin
      if (strb.ackStrb && strb.ackOneHot[SLOT_RST]) resetPendQ <= 1'b0;
      if (intDis)      enQ <= 1'b0;
      else if (intEna) enQ <= 1'b1;
      blankQ <= maskWr;
      if (maskWr) maskQ <= maskData;
      if (ctrlWr) ctrlQ <= irqcCtrl_t'(ctrlData);
      inSvcQ <= svcNext;
    end
  end

  assign pendVec = reqRaw & {maskQ, {FIRST_MASKABLE{1'b1}}};
  assign inSvc   = inSvcQ;
  assign nestEn  = ctrlQ.nestEn;
  assign globEn  = enQ;
  assign blank   = blankQ;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NUM_SLOTS-1:0] pendVec,
  input  logic [NUM_SLOTS-1:0] inSvc,
  input  logic                 nestEn,
  input  logic                 globEn,
  input  logic                 blank,
  input  logic                 vecAck,
  input  logic                 vecRet,
  output logic                 vecValid,
  output logic [VEC_W-1:0]     vecAddr,
  output irqcStrobes_t         strb
);
  logic [IDX_W-1:0]     winIdx;
  logic [NUM_SLOTS-1:0] winOneHot, atOrAbove;
  logic                 found, nestOk;

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (pendVec[i]) winIdx = IDX_W'(i);
  end

  assign found     = |pendVec;
  assign winOneHot = pendVec & (~pendVec + 1'b1);
  assign atOrAbove = (winOneHot << 1) - 1'b1;
  assign nestOk    = nestEn ? ((inSvc & atOrAbove) == '0) : (inSvc == '0);
  assign vecValid  = found & (winOneHot[SLOT_RST] | (globEn & ~blank & nestOk));
  assign vecAddr   = slotVector(int'(winIdx));

  assign strb.ackStrb   = vecAck & vecValid;
  assign strb.ackOneHot = winOneHot;
  assign strb.retStrb   = vecRet;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    irq2N,
  input  logic                    irql1N,
  input  logic                    irql0N,
  input  logic                    irqeN,
  input  logic                    irq1N,
  input  logic                    irq0N,
  input  logic                    pdReq,
  input  logic                    ser0TxReq,
  input  logic                    ser0RxReq,
  input  logic                    dmaReq,
  input  logic                    ser1TxReq,
  input  logic                    ser1RxReq,
  input  logic                    timerReq,
  input  logic                    ser1AsIrq,
  input  logic                    maskWr,
  input  logic [NUM_MASKABLE-1:0] maskData,
  input  logic                    ctrlWr,
  input  logic [CTRL_W-1:0]       ctrlData,
  input  logic                    forceWr,
  input  logic [NUM_MASKABLE-1:0] forceSet,
  input  logic [NUM_MASKABLE-1:0] forceClr,
  input  logic                    intEna,
  input  logic                    intDis,
  input  logic                    vecAck,
  input  logic                    vecRet,
  output logic                    vecValid,
  output logic [VEC_W-1:0]        vecAddr
);
  irqcStrobes_t         strb;
  logic [NUM_SLOTS-1:0] pendVec, inSvc;
  logic                 nestEn, globEn, blank;

  irqc_req_path u_path (
    .clk, .rstN, .irq2N, .irql1N, .irql0N, .irqeN, .irq1N, .irq0N,
    .pdReq, .ser0TxReq, .ser0RxReq, .dmaReq, .ser1TxReq, .ser1RxReq,
    .timerReq, .ser1AsIrq, .maskWr, .maskData, .ctrlWr, .ctrlData,
    .forceWr, .forceSet, .forceClr, .intEna, .intDis, .strb,
    .pendVec, .inSvc, .nestEn, .globEn, .blank
  );

  irqc_arbiter u_arb (
    .pendVec, .inSvc, .nestEn, .globEn, .blank, .vecAck, .vecRet,
    .vecValid, .vecAddr, .strb
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irqc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 maskWr,
  input logic                 vecAck,
  input logic                 vecValid,
  input logic [VEC_W-1:0]     vecAddr,
  input logic                 globEn,
  input logic                 nestEn,
  input logic [NUM_SLOTS-1:0] inSvc
);
  p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr[1:0] == 2'b00 && vecAddr <= PD_VEC));

  p_mask_blank_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(maskWr) |-> (!vecValid || vecAddr == '0));

  p_global_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !globEn) |-> vecAddr == '0);

  p_nest_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !nestEn && inSvc != '0) |-> vecAddr == '0);

  p_ack_retires_r13: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && vecValid) |=> !(vecValid && vecAddr == $past(vecAddr)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .maskWr(maskWr), .vecAck(vecAck),
  .vecValid(vecValid), .vecAddr(vecAddr), .globEn(globEn),
  .nestEn(nestEn), .inSvc(inSvc)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irq2N = 1, irql1N = 1, irql0N = 1, irqeN = 1, irq1N = 1, irq0N = 1;
  logic pdReq = 0, ser0TxReq = 0, ser0RxReq = 0, dmaReq = 0;
  logic ser1TxReq = 0, ser1RxReq = 0, timerReq = 0, ser1AsIrq = 0;
  logic maskWr = 0, ctrlWr = 0, forceWr = 0, intEna = 0, intDis = 0;
  logic vecAck = 0, vecRet = 0;
  logic [9:0]  maskData = '0, forceSet = '0, forceClr = '0;
  logic [3:0]  ctrlData = '0;
  logic        vecValid;
  logic [15:0] vecAddr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut_i (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, bit expValid, logic [15:0] expAddr);
    checks++;
    if (vecValid !== expValid || (expValid && vecAddr !== expAddr)) begin
      fails++;
      $display("FAIL %s: valid=%0b addr=%04h expected valid=%0b addr=%04h",
               req, vecValid, vecAddr, expValid, expAddr);
    end
  endtask

  task automatic doAck(); vecAck = 1; tick(); vecAck = 0; endtask
  task automatic doRet(); vecRet = 1; tick(); vecRet = 0; endtask
  task automatic writeMask(logic [9:0] m);
    maskWr = 1; maskData = m; tick(); maskWr = 0; tick();
  endtask
  task automatic writeCtrl(logic [3:0] c);
    ctrlWr = 1; ctrlData = c; tick(); ctrlWr = 0;
  endtask

  task automatic testReset();
    chk("R1 held in reset", 1, 16'h0000);
    repeat (3) tick();
    rstN = 1; tick();
    chk("R1 reset vector after release", 1, 16'h0000);
    timerReq = 1; tick(); timerReq = 0;
    chk("R1 mask clear, reset still first", 1, 16'h0000);
    doAck();
    chk("R1 reset retired, timer masked", 0, 0);
  endtask

  task automatic testPriority();
    writeMask(10'h3FF);
    chk("R2 timer latched but blocked?", 1, 16'h0028); // timer pulse from R1 test is pending
    doAck(); doRet();
    timerReq = 1; dmaReq = 1; ser0RxReq = 1; tick();
    timerReq = 0; dmaReq = 0; ser0RxReq = 0;
    chk("R2 serial0 rx wins", 1, 16'h0014);
    doAck();
    chk("R10 blocked while in service", 0, 0);
    doRet();
    chk("R2 dma next", 1, 16'h001C);
    doAck(); doRet();
    chk("R2 timer last", 1, 16'h0028);
    doAck(); doRet();
    pdReq = 1; ser0TxReq = 1; tick(); pdReq = 0; ser0TxReq = 0;
    chk("R2 power-down above all lines", 1, 16'h002C);
    doAck(); doRet();
    chk("R2 serial0 tx", 1, 16'h0010);
    doAck(); doRet();
    chk("R2 idle", 0, 0);
  endtask

  task automatic testMask();
    writeMask(10'h000);
    timerReq = 1; tick(); timerReq = 0;
    chk("R3 masked timer hidden", 0, 0);
    maskWr = 1; maskData = 10'h200; tick(); maskWr = 0;
    chk("R4 blank cycle after mask write", 0, 0);
    tick();
    chk("R3 timer after unmask", 1, 16'h0028);
    doAck(); doRet();
    pdReq = 1; tick(); pdReq = 0;
    chk("R3 power-down ignores mask", 1, 16'h002C);
    doAck(); doRet();
  endtask

  task automatic testGlobal();
    intDis = 1; tick(); intDis = 0;
    pdReq = 1; tick(); pdReq = 0;
    chk("R5 disabled blocks power-down", 0, 0);
    intEna = 1; intDis = 1; tick(); intEna = 0; intDis = 0;
    chk("R5 disable wins over enable", 0, 0);
    intEna = 1; tick(); intEna = 0;
    chk("R5 enable restores", 1, 16'h002C);
    doAck(); doRet();
  endtask

  task automatic testLevelEdge();
    writeMask(10'h3FF);
    irql0N = 0;
    chk("R13 not visible before edge", 0, 0);
    tick();
    chk("R6 level L0 shown", 1, 16'h000C);
    irql0N = 1; tick();
    chk("R6 level not latched", 0, 0);
    irqeN = 0; tick(); irqeN = 1; tick();
    chk("R7 edge E held", 1, 16'h0018);
    doAck();
    chk("R13 acked vector not repeated", 0, 0);
    doRet();
    chk("R7 latch cleared by ack", 0, 0);
  endtask

  task automatic testConfig();
    irq2N = 0; tick();
    chk("R8 IRQ2 level mode", 1, 16'h0004);
    irq2N = 1; tick();
    chk("R8 IRQ2 level released", 0, 0);
    writeCtrl(4'b0100);
    irq2N = 0; tick(); irq2N = 1; tick();
    chk("R8 IRQ2 edge mode latched", 1, 16'h0004);
    doAck(); doRet();
    chk("R8 IRQ2 edge cleared", 0, 0);
  endtask

  task automatic testForce();
    forceWr = 1; forceSet = 10'h040; tick(); forceWr = 0; forceSet = '0;
    chk("R9 force DMA latch", 1, 16'h001C);
    forceWr = 1; forceClr = 10'h040; tick(); forceWr = 0; forceClr = '0;
    chk("R9 clear DMA latch", 0, 0);
    forceWr = 1; forceSet = 10'h002; tick(); forceWr = 0; forceSet = '0;
    chk("R9 force on level slot ignored", 0, 0);
  endtask

  task automatic testNest();
    writeCtrl(4'b1000);
    timerReq = 1; tick(); timerReq = 0;
    chk("R11 timer offered", 1, 16'h0028);
    doAck();
    dmaReq = 1; tick(); dmaReq = 0;
    chk("R11 higher pre-empts", 1, 16'h001C);
    doAck();
    timerReq = 1; tick(); timerReq = 0;
    chk("R11 lower blocked", 0, 0);
    doRet();
    chk("R11 equal blocked after first return", 0, 0);
    doRet();
    chk("R10 return reopens timer", 1, 16'h0028);
    doAck(); doRet();
    writeCtrl(4'b0000);
  endtask

  task automatic testSer1();
    irq0N = 0; tick();
    chk("R12 IRQ0 line ignored in serial mode", 0, 0);
    irq0N = 1; tick();
    ser1RxReq = 1; tick(); ser1RxReq = 0;
    chk("R12 serial1 rx pulse", 1, 16'h0024);
    doAck(); doRet();
    ser1AsIrq = 1; tick();
    irq0N = 0; tick();
    chk("R12 IRQ0 line in line mode", 1, 16'h0024);
    irq0N = 1; tick();
    chk("R12 IRQ0 level released", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testPriority();
    testMask();
    testGlobal();
    testLevelEdge();
    testConfig();
    testForce();
    testNest();
    testSer1();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule